// File: doc/BRIEF.md
# Multi-domain reset sequencer

This block drives up to four active-low reset outputs, one for each reset domain of a chip. A domain is put into reset by any of four sources: the power-on reset, a cleared enable bit for that domain, a one-cycle software trigger strobe for that domain, or a watchdog reset request that reaches every domain selected by a parameter mask. A reset output goes low at once, with no clock edge needed. It comes back high only on a rising clock edge, after a minimum hold time that counts from the moment the last request ends.

Each domain has three parts. A request stage combines the sources and turns the software strobe into a pending bit that clears itself. A hold counter is loaded asynchronously while any request is present and counts down once all requests have gone. A synchronizer chain is cleared asynchronously by the request and fills with ones only after the counter reaches zero. A per-domain in-reset status output mirrors each reset for the logic that watches it. The enable bits, the trigger strobes and the watchdog request come from a register bank and a watchdog counter outside the block. Here they are plain ports.

Top module: `rstseq_top`

## Requirements
- R1: Parameters NUM_DOMAINS (1 to 4, default 4), HOLD_CYCLES (at least 1, default 16) and SYNC_STAGES (at least 2, default 2) are checked at elaboration. Bit i of every per-domain vector port belongs to domain i, and all NUM_DOMAINS domains behave identically.
- R2: While por_ni is 0, every dom_rst_no bit is 0, with no clock edge needed. After por_ni rises between two clock edges, each domain whose enable is 1 drives its output to 1 on the (HOLD_CYCLES+SYNC_STAGES)-th rising edge after the release.
- R3: dom_en_i[i]=0 drives dom_rst_no[i] to 0 before the next clock edge and keeps it 0 for as long as the enable stays 0. Other domains are unaffected.
- R4: When dom_en_i[i] returns to 1 between two edges, dom_rst_no[i] rises on the (HOLD_CYCLES+SYNC_STAGES)-th rising edge after that change.
- R5: A rising edge that samples sw_trig_i[i]=1 drives dom_rst_no[i] to 0 right after that edge. The output rises on the (HOLD_CYCLES+SYNC_STAGES+1)-th rising edge after the last edge that sampled the strobe. Other domains are unaffected.
- R6: The software trigger clears itself. One strobe produces exactly one reset pulse, and the output then stays 1 with no further input activity.
- R7: wdog_req_i=1 drives dom_rst_no[i] to 0 at once for every domain whose WDOG_MASK bit i is 1 (default: all bits 1). When the request drops between edges, release follows the R4 timing.
- R8: A request that arrives while a domain is still counting its hold time restarts the count. Release is then timed from the end of the newest request.
- R9: in_reset_o[i] is 1 exactly when dom_rst_no[i] is 0.
- R10: A reset output changes from 0 to 1 only at a rising clock edge, and only after the hold counter has reached zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| por_ni | input | 1 | Power-on reset, active low, asynchronous |
| dom_en_i | input | NUM_DOMAINS | Per-domain enable; 1 = run, 0 = hold in reset |
| sw_trig_i | input | NUM_DOMAINS | Per-domain software reset strobe |
| wdog_req_i | input | 1 | Watchdog reset request, level |
| dom_rst_no | output | NUM_DOMAINS | Per-domain reset, active low |
| in_reset_o | output | NUM_DOMAINS | Per-domain in-reset status, 1 = in reset |

## Verification
The assertions assume that the enable bits, the software strobes and the watchdog request are driven from the same clock domain as clk_i. They may change anywhere between edges but stay stable around each rising edge. With that assumption, the self-clear of the pending trigger and the reload of the hold counter can be checked at sampled edges. The bench changes every input on the falling clock edge. It never toggles a request inside the setup window of a rising edge, and it samples the outputs shortly after each rising edge. As a result, the edge-count expectations derived from the requirements are exact.

// File: rtl/rstseq_pkg.sv
package rstseq_pkg;
   localparam int unsigned MAX_DOMAINS = 4;
   localparam int unsigned MIN_SYNC    = 2;

   // bits needed to hold a count from 0 up to and including hold
   function automatic int unsigned hold_cnt_width(input int unsigned hold);
      int unsigned w;
      w = 1;
      while ((64'd1 << w) <= 64'(hold)) w++;
      return w;
   endfunction
endpackage

// File: rtl/rstseq_hold.sv
module rstseq_hold #(
   parameter int unsigned HOLD_CYCLES = 16
) (
   input  logic clk_i,
   input  logic arst_ni,   // low while any reset request is present
   output logic busy_o
);
   localparam int unsigned CW = rstseq_pkg::hold_cnt_width(HOLD_CYCLES);
   localparam logic [CW-1:0] LOAD = CW'(HOLD_CYCLES);

   logic [CW-1:0] cnt_q;

   // loaded asynchronously while a request is present, counts down after it
   always_ff @(posedge clk_i or negedge arst_ni) begin
      if (!arst_ni)            cnt_q <= LOAD;
      else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
   end

   assign busy_o = (cnt_q != '0);

   // counter never leaves its legal range
   p_cnt_range_r10: assert property (@(posedge clk_i) disable iff (!arst_ni)
      cnt_q <= LOAD);
   // a running count moves down by one each edge
   p_cnt_step_r8: assert property (@(posedge clk_i) disable iff (!arst_ni)
      (cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1) || !arst_ni);
endmodule

// File: rtl/rstseq_sync.sv
module rstseq_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk_i,
   input  logic arst_ni,
   input  logic hold_i,
   output logic rst_no
);
   logic [STAGES-1:0] chain_q;

   // cleared at once by the request, refilled with ones only after the hold ends
   always_ff @(posedge clk_i or negedge arst_ni) begin
      if (!arst_ni) chain_q <= '0;
      else          chain_q <= {chain_q[STAGES-2:0], ~hold_i};
   end

   assign rst_no = chain_q[STAGES-1];

   // while the hold is active the chain head stays low
   p_head_follows_hold_r10: assert property (@(posedge clk_i) disable iff (!arst_ni)
      hold_i |=> !chain_q[0]);
endmodule

// File: rtl/rstseq_domain.sv
module rstseq_domain #(
   parameter int unsigned HOLD_CYCLES = 16,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic clk_i,
   input  logic por_ni,
   input  logic en_i,
   input  logic sw_trig_i,
   input  logic wdog_hit_i,
   output logic rst_no
);
   logic sw_pend_q;
   logic req;
   logic raw_rst_n;
   logic busy;

   // self-clearing software trigger: holds a strobe for exactly one cycle
   always_ff @(posedge clk_i or negedge por_ni) begin
      if (!por_ni) sw_pend_q <= 1'b0;
      else         sw_pend_q <= sw_trig_i;
   end

   assign req       = ~en_i | sw_pend_q | wdog_hit_i;
   assign raw_rst_n = por_ni & ~req;

   rstseq_hold #(.HOLD_CYCLES(HOLD_CYCLES)) u_hold (
      .clk_i  (clk_i),
      .arst_ni(raw_rst_n),
      .busy_o (busy)
   );

   rstseq_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk_i  (clk_i),
      .arst_ni(raw_rst_n),
      .hold_i (busy),
      .rst_no (rst_no)
   );

   p_en_forces_r3: assert property (@(posedge clk_i) disable iff (!por_ni)
      !en_i |-> !rst_no);
   p_sw_self_clear_r6: assert property (@(posedge clk_i) disable iff (!por_ni)
      (sw_pend_q && !sw_trig_i) |=> !sw_pend_q);
   p_busy_blocks_r4: assert property (@(posedge clk_i) disable iff (!por_ni)
      busy |=> !rst_no);
   p_req_loads_r8: assert property (@(posedge clk_i) disable iff (!por_ni)
      req |-> (busy && !rst_no));
   p_trig_resets_r5: assert property (@(posedge clk_i) disable iff (!por_ni)
      sw_trig_i |=> !rst_no);
endmodule

// File: rtl/rstseq_top.sv
module rstseq_top #(
   parameter int unsigned NUM_DOMAINS = 4,
   parameter int unsigned HOLD_CYCLES = 16,
   parameter int unsigned SYNC_STAGES = 2,
   parameter logic [3:0]  WDOG_MASK   = 4'hF
) (
   input  logic                   clk_i,
   input  logic                   por_ni,
   input  logic [NUM_DOMAINS-1:0] dom_en_i,
   input  logic [NUM_DOMAINS-1:0] sw_trig_i,
   input  logic                   wdog_req_i,
   output logic [NUM_DOMAINS-1:0] dom_rst_no,
   output logic [NUM_DOMAINS-1:0] in_reset_o
);
   // R1: elaboration-time parameter checks
   if (NUM_DOMAINS < 1 || NUM_DOMAINS > rstseq_pkg::MAX_DOMAINS) begin : g_bad_num_r1
      $error("NUM_DOMAINS out of range");
   end
   if (HOLD_CYCLES < 1) begin : g_bad_hold_r1
      $error("HOLD_CYCLES must be at least 1");
   end
   if (SYNC_STAGES < rstseq_pkg::MIN_SYNC) begin : g_bad_sync_r1
      $error("SYNC_STAGES must be at least 2");
   end

   for (genvar g = 0; g < NUM_DOMAINS; g++) begin : g_dom
      logic wdog_hit;

      if (WDOG_MASK[g]) begin : g_wdog_on
         assign wdog_hit = wdog_req_i;
      end else begin : g_wdog_off
         assign wdog_hit = 1'b0;
      end

      rstseq_domain #(
         .HOLD_CYCLES(HOLD_CYCLES),
         .SYNC_STAGES(SYNC_STAGES)
      ) u_dom (
         .clk_i     (clk_i),
         .por_ni    (por_ni),
         .en_i      (dom_en_i[g]),
         .sw_trig_i (sw_trig_i[g]),
         .wdog_hit_i(wdog_hit),
         .rst_no    (dom_rst_no[g])
      );

      // R7: a masked-in watchdog request holds the domain
      p_wdog_forces_r7: assert property (@(posedge clk_i) disable iff (!por_ni)
         (wdog_req_i && WDOG_MASK[g]) |-> !dom_rst_no[g]);
      // R10: release only when every request was absent on the previous edge
      p_release_clean_r10: assert property (@(posedge clk_i) disable iff (!por_ni)
         $rose(dom_rst_no[g]) |-> $past(dom_en_i[g] && !sw_trig_i[g]));
   end

   assign in_reset_o = ~dom_rst_no;   // R9
endmodule

// File: tb/sim_rstseq_top.sv
module sim_rstseq_top;
   localparam int N = 4;
   localparam int H = 6;
   localparam int S = 2;

   typedef struct packed {
      logic [1:0] kind;   // 0 enable drop, 1 software strobe, 2 watchdog
      logic [1:0] dom;
      logic [3:0] len;    // cycles the request is held
   } vec_t;

   localparam vec_t VECS [6] = '{
      '{2'd0, 2'd0, 4'd1},
      '{2'd0, 2'd3, 4'd5},
      '{2'd1, 2'd1, 4'd1},
      '{2'd1, 2'd2, 4'd3},
      '{2'd2, 2'd0, 4'd2},
      '{2'd1, 2'd3, 4'd1}
   };

   logic         clk = 1'b0;
   logic         por_n;
   logic [N-1:0] en;
   logic [N-1:0] sw;
   logic         wd;
   logic [N-1:0] rst_n;
   logic [N-1:0] in_rst;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #4 clk = ~clk;   // 125 MHz

   rstseq_top #(.NUM_DOMAINS(N), .HOLD_CYCLES(H), .SYNC_STAGES(S)) u0 (
      .clk_i     (clk),
      .por_ni    (por_n),
      .dom_en_i  (en),
      .sw_trig_i (sw),
      .wdog_req_i(wd),
      .dom_rst_no(rst_n),
      .in_reset_o(in_rst)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic count_release(input int d, output int n);
      n = 0;
      do begin
         @(posedge clk); #1;
         n++;
      end while (!rst_n[d] && n < 300);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   endtask

   initial begin
      #(8 * 20000);
      checks++; errors++;
      $display("FAIL watchdog timeout actual=%0d expected=%0d", 0, 1);
      finish_run();
   end

   initial begin
      int n;
      int exp;
      logic [N-1:0] others;
      por_n = 1'b0; en = '1; sw = '0; wd = 1'b0;
      #1;
      chk(rst_n == '0, "R2 outputs low during power-on reset", int'(rst_n), 0);
      chk(in_rst == '1, "R9 status high during power-on reset", int'(in_rst), 15);
      repeat (3) @(posedge clk);
      @(negedge clk) por_n = 1'b1;
      count_release(0, n);
      chk(n == H + S, "R2 release edge after power-on", n, H + S);
      chk(rst_n == '1, "R1 all domains released together", int'(rst_n), 15);
      chk(in_rst == '0, "R9 status low when released", int'(in_rst), 0);

      // table-driven walk
      foreach (VECS[i]) begin
         int d;
         d = int'(VECS[i].dom);
         @(negedge clk);
         case (VECS[i].kind)
            2'd0: begin
               en[d] = 1'b0; #1;
               chk(rst_n[d] == 1'b0, "R3 enable drop asserts before edge", int'(rst_n[d]), 0);
               others = rst_n; others[d] = 1'b1;
               chk(others == '1, "R3 other domains unaffected", int'(others), 15);
               chk(in_rst[d] == 1'b1, "R9 status follows reset", int'(in_rst[d]), 1);
               repeat (int'(VECS[i].len)) @(posedge clk);
               #1;
               chk(rst_n[d] == 1'b0, "R3 held while enable low", int'(rst_n[d]), 0);
               @(negedge clk) en[d] = 1'b1;
               exp = H + S;
            end
            2'd1: begin
               sw[d] = 1'b1;
               @(posedge clk); #1;
               chk(rst_n[d] == 1'b0, "R5 strobe asserts after sampling edge", int'(rst_n[d]), 0);
               others = rst_n; others[d] = 1'b1;
               chk(others == '1, "R5 other domains unaffected", int'(others), 15);
               repeat (int'(VECS[i].len) - 1) @(posedge clk);
               @(negedge clk) sw[d] = 1'b0;
               exp = H + S + 1;
            end
            default: begin
               wd = 1'b1; #1;
               chk(rst_n == '0, "R7 watchdog asserts all domains", int'(rst_n), 0);
               repeat (int'(VECS[i].len)) @(posedge clk);
               @(negedge clk) wd = 1'b0;
               exp = H + S;
            end
         endcase
         count_release(d, n);
         chk(n == exp, (VECS[i].kind == 2'd0) ? "R4 enable release edge" :
                       (VECS[i].kind == 2'd1) ? "R5 strobe release edge" :
                                                "R7 watchdog release edge", n, exp);
         chk(rst_n == '1, "R10 all domains out of reset after release", int'(rst_n), 15);
         repeat (2 * H) @(posedge clk);
         #1;
         chk(rst_n[d] == 1'b1, "R6 no further reset without action", int'(rst_n[d]), 1);
      end

      // R8: retrigger during the hold restarts the count
      @(negedge clk) sw[1] = 1'b1;
      @(negedge clk) sw[1] = 1'b0;
      repeat (H - 2) @(posedge clk);
      @(negedge clk) sw[1] = 1'b1;
      @(negedge clk) sw[1] = 1'b0;
      count_release(1, n);
      chk(n == H + S + 1, "R8 hold restarted by second trigger", n, H + S + 1);

      // R7 + R3: watchdog ends while enable still holds domain 2
      @(negedge clk) begin en[2] = 1'b0; wd = 1'b1; end
      repeat (2) @(posedge clk);
      @(negedge clk) wd = 1'b0;
      count_release(0, n);
      chk(n == H + S, "R7 unheld domain releases on time", n, H + S);
      chk(rst_n[2] == 1'b0, "R3 enable keeps domain held past watchdog", int'(rst_n[2]), 0);
      chk(in_rst == 4'b0100, "R9 status shows only held domain", int'(in_rst), 4);
      @(negedge clk) en[2] = 1'b1;
      count_release(2, n);
      chk(n == H + S, "R4 release after late enable", n, H + S);

      // R2: power-on reset in mid-run asserts everything at once
      @(negedge clk) por_n = 1'b0;
      #1;
      chk(rst_n == '0, "R2 power-on reset asserts asynchronously", int'(rst_n), 0);
      @(negedge clk) por_n = 1'b1;
      count_release(3, n);
      chk(n == H + S, "R2 release after second power-on", n, H + S);

      finish_run();
   end
endmodule